// File: doc/BRIEF.md
# Sub-word Write Packer for a Hash Message Port

This block sits between a 32-bit peripheral write port and a hash engine that takes whole 32-bit message words. Software or a DMA channel may feed the message as single bytes, halfwords or full words. The block places each accepted write into a word buffer at the current byte offset, filling from the least significant byte lane upward. Because of this little-endian packing, one memory buffer produces the same message word whatever transfer size was used to send it.

When a word is complete, the block can reverse its byte order before passing it on. The hash engine expects the first message byte in the most significant lane, so this swap is on after reset. A write that arrives while the engine cannot accept data is dropped and sets a sticky error flag. A start pulse clears any partly filled word before a new message begins.

Top module: `subword_packer`

## Requirements
- R1: A write with size code 2 or 3 (a word) always completes a word. One cycle after the write is accepted, `word_vld_o` is high for that cycle. When swapping is off and the buffer was empty, `word_o` equals the written data.
- R2: With size code 0 (a byte), only `wr_data_i[7:0]` is used. Four accepted byte writes form a word, and the first byte lands in bits 7:0 while the fourth lands in bits 31:24. `word_vld_o` pulses only after the fourth byte.
- R3: With size code 1 (a halfword), only `wr_data_i[15:0]` is used. Two accepted halfword writes form a word with the first halfword in bits 15:0. `word_vld_o` pulses only after the second halfword.
- R4: `swap_o` resets to 1. A `swap_wr_i` pulse loads `swap_val_i` into it for the next cycle. While it is 1, a completed word is presented with its bytes reversed: bits 7:0 move to 31:24, and so on.
- R5: A write with `rdy_i` low sets `err_o` in the next cycle. `err_o` then stays high until it is cleared.
- R6: A write with `rdy_i` low is dropped. It produces no `word_vld_o` pulse and does not move the byte offset.
- R7: An `err_clr_i` pulse clears `err_o` in the next cycle. If a rejected write arrives in the same cycle, the error is set instead.
- R8: A `clear_i` pulse returns the byte offset to zero and empties the partial word. A write in the same cycle is not accepted and gives no `word_vld_o` pulse.
- R9: Mixed sizes are packed in order at the current byte offset. Bytes that would lie above bit 31 are discarded. The word completes as soon as the offset reaches or passes four bytes.
- R10: After reset, `word_vld_o` and `err_o` are 0, `word_o` is 0 and `swap_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Start of a new message: empties the partial word |
| wr_en_i | input | 1 | Write strobe for the data port |
| wr_size_i | input | 2 | Transfer size: 0 byte, 1 halfword, 2 or 3 word |
| wr_data_i | input | 32 | Write data, low lanes used for sub-word sizes |
| rdy_i | input | 1 | Hash engine can accept data |
| err_clr_i | input | 1 | Clears the sticky error flag |
| swap_wr_i | input | 1 | Loads the byte-reverse enable |
| swap_val_i | input | 1 | New value of the byte-reverse enable |
| word_vld_o | output | 1 | One-cycle pulse when a packed word is presented |
| word_o | output | 32 | Packed, optionally byte-reversed word |
| err_o | output | 1 | Sticky flag: a write arrived while not ready |
| swap_o | output | 1 | Current byte-reverse enable |

## Verification
Some rules are checked by the bound assertions on every cycle: the error flag sets, holds and clears as required; a rejected or cleared write never yields a word pulse; every pulse traces back to an accepted write; a word-size write always yields a pulse; and the swap enable follows its load. The bench scenarios are needed for the lane placement and the byte order of the packed data. They also show that the offset holds across a dropped write, that a start pulse throws away a half-built word, and how mixed sizes wrap at the word boundary. All of these depend on data values across several writes, which a single-cycle property cannot see.

// File: rtl/subword_packer_pkg.sv
package subword_packer_pkg;

    // Transfer size codes on the write port.
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD3 = 2'd3
    } wsize_e;

endpackage

// File: rtl/subword_lane_merge.sv
module subword_lane_merge
    import subword_packer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W,
    localparam int CNT_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [1:0]        size_i,
    input  logic [CNT_W-1:0]  off_i,
    output logic [DATA_W-1:0] merged_o,
    output logic [CNT_W:0]    sum_o,
    output logic              full_o
);

    logic [CNT_W:0] nbytes;

    always_comb begin
        case (wsize_e'(size_i))
            SZ_BYTE: nbytes = (CNT_W+1)'(1);
            SZ_HALF: nbytes = (CNT_W+1)'(LANES / 2);
            default: nbytes = (CNT_W+1)'(LANES);
        endcase
        sum_o  = {1'b0, off_i} + nbytes;
        full_o = (sum_o >= (CNT_W+1)'(LANES));
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [CNT_W:0]   idx_w;
        logic [CNT_W-1:0] src;
        logic             hit;
        always_comb begin
            idx_w = (CNT_W+1)'(i);
            hit   = (idx_w >= {1'b0, off_i}) && (idx_w < sum_o);
            src   = CNT_W'(i) - off_i;
            merged_o[i*LANE_W +: LANE_W] = hit ? data_i[src*LANE_W +: LANE_W]
                                               : acc_i[i*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/subword_byte_swap.sv
module subword_byte_swap #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o
);

    for (genvar i = 0; i < LANES; i++) begin : g_rev
        assign dout_o[i*LANE_W +: LANE_W] = din_i[(LANES-1-i)*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/subword_packer.sv
module subword_packer #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_size_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rdy_i,
    input  logic              err_clr_i,
    input  logic              swap_wr_i,
    input  logic              swap_val_i,
    output logic              word_vld_o,
    output logic [DATA_W-1:0] word_o,
    output logic              err_o,
    output logic              swap_o
);

    localparam int LANES = DATA_W / LANE_W;
    localparam int CNT_W = $clog2(LANES);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] word;
        logic              vld;
        logic              err;
        logic              swap;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] swapped;
    logic [CNT_W:0]    sum;
    logic              full;
    logic              accept;
    logic              reject;

    subword_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_merge (
        .acc_i    (st_q.acc),
        .data_i   (wr_data_i),
        .size_i   (wr_size_i),
        .off_i    (st_q.cnt),
        .merged_o (merged),
        .sum_o    (sum),
        .full_o   (full)
    );

    subword_byte_swap #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_swap (
        .din_i  (merged),
        .dout_o (swapped)
    );

    always_comb begin
        accept = wr_en_i && rdy_i && !clear_i;
        reject = wr_en_i && !rdy_i;

        st_d     = st_q;
        st_d.vld = 1'b0;

        if (swap_wr_i) begin
            st_d.swap = swap_val_i;
        end

        if (err_clr_i) begin
            st_d.err = 1'b0;
        end
        if (reject) begin
            st_d.err = 1'b1;
        end

        if (clear_i) begin
            st_d.cnt = '0;
            st_d.acc = '0;
        end else if (accept) begin
            if (full) begin
                st_d.word = st_q.swap ? swapped : merged;
                st_d.vld  = 1'b1;
                st_d.cnt  = '0;
                st_d.acc  = '0;
            end else begin
                st_d.cnt = sum[CNT_W-1:0];
                st_d.acc = merged;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.swap <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_vld_o = st_q.vld;
    assign word_o     = st_q.word;
    assign err_o      = st_q.err;
    assign swap_o     = st_q.swap;

endmodule

// File: rtl/subword_packer_chk.sv
module subword_packer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              clear_i,
    input logic              wr_en_i,
    input logic [1:0]        wr_size_i,
    input logic              rdy_i,
    input logic              err_clr_i,
    input logic              swap_wr_i,
    input logic              swap_val_i,
    input logic              word_vld_o,
    input logic [DATA_W-1:0] word_o,
    input logic              err_o,
    input logic              swap_o
);

    a_r1_word_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && rdy_i && !clear_i && wr_size_i[1]) |=> word_vld_o);

    a_r2_pulse_from_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_vld_o |-> $past(wr_en_i && rdy_i && !clear_i));

    a_r4_swap_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        swap_wr_i |=> (swap_o == $past(swap_val_i)));

    a_r5_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !rdy_i) |=> err_o);

    a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o && !err_clr_i) |=> err_o);

    a_r6_drop_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !rdy_i) |=> !word_vld_o);

    a_r7_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_clr_i && !(wr_en_i && !rdy_i)) |=> !err_o);

    a_r8_clear_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> !word_vld_o);

    a_r4_swap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !swap_wr_i |=> $stable(swap_o));

endmodule

bind subword_packer subword_packer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .wr_en_i    (wr_en_i),
    .wr_size_i  (wr_size_i),
    .rdy_i      (rdy_i),
    .err_clr_i  (err_clr_i),
    .swap_wr_i  (swap_wr_i),
    .swap_val_i (swap_val_i),
    .word_vld_o (word_vld_o),
    .word_o     (word_o),
    .err_o      (err_o),
    .swap_o     (swap_o)
);

// File: tb/subword_packer_tb.sv
`timescale 1ns/1ps
module subword_packer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_size = 2'd0;
    logic [31:0] wr_data = '0;
    logic        rdy = 1'b1;
    logic        err_clr = 1'b0;
    logic        swap_wr = 1'b0;
    logic        swap_val = 1'b0;
    logic        word_vld;
    logic [31:0] word;
    logic        err;
    logic        swap;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    subword_packer u_dut (
        .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .wr_en_i(wr_en),
        .wr_size_i(wr_size), .wr_data_i(wr_data), .rdy_i(rdy),
        .err_clr_i(err_clr), .swap_wr_i(swap_wr), .swap_val_i(swap_val),
        .word_vld_o(word_vld), .word_o(word), .err_o(err), .swap_o(swap)
    );

    // {size, data, expect pulse, expect word}; swap disabled while walking
    localparam int NV = 16;
    localparam logic [66:0] VEC [NV] = '{
        {2'd0, 32'h0000_0011, 1'b0, 32'h0},          // R2
        {2'd0, 32'hFFFF_FF22, 1'b0, 32'h0},          // R2
        {2'd0, 32'h0000_0033, 1'b0, 32'h0},          // R2
        {2'd0, 32'h0000_0044, 1'b1, 32'h4433_2211},  // R2
        {2'd1, 32'hFFFF_2211, 1'b0, 32'h0},          // R3
        {2'd1, 32'h0000_4433, 1'b1, 32'h4433_2211},  // R3
        {2'd2, 32'h4433_2211, 1'b1, 32'h4433_2211},  // R1
        {2'd0, 32'h0000_0055, 1'b0, 32'h0},          // R9
        {2'd1, 32'h0000_7766, 1'b0, 32'h0},          // R9
        {2'd0, 32'h0000_0088, 1'b1, 32'h8877_6655},  // R9
        {2'd0, 32'h0000_0001, 1'b0, 32'h0},          // R9
        {2'd0, 32'h0000_0002, 1'b0, 32'h0},          // R9
        {2'd0, 32'h0000_0003, 1'b0, 32'h0},          // R9
        {2'd1, 32'h0000_BEEF, 1'b1, 32'hEF03_0201},  // R9 overflow dropped
        {2'd0, 32'h0000_0099, 1'b0, 32'h0},          // R9
        {2'd3, 32'h1234_5678, 1'b1, 32'h3456_7899}   // R9 word at offset 1
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_size = sz; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
    endtask

    task automatic pulse_err_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic load_swap(input logic v);
        @(negedge clk); swap_wr = 1'b1; swap_val = v;
        @(negedge clk); swap_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 vld", {31'd0, word_vld}, 32'd0);
        check("R10 err", {31'd0, err}, 32'd0);
        check("R10 word", word, 32'd0);
        check("R10 swap", {31'd0, swap}, 32'd1);

        // R4 swap on by default: first byte ends up most significant
        do_wr(2'd0, 32'h61); do_wr(2'd0, 32'h62); do_wr(2'd0, 32'h63);
        check("R4 no early pulse", {31'd0, word_vld}, 32'd0);
        do_wr(2'd0, 32'h64);
        check("R4 vld", {31'd0, word_vld}, 32'd1);
        check("R4 swapped word", word, 32'h6162_6364);
        load_swap(1'b0);
        check("R4 swap load", {31'd0, swap}, 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [66:0] v;
            v = VEC[i];
            do_wr(v[66:65], v[64:33]);
            check($sformatf("R1/R2/R3/R9 vec%0d vld", i), {31'd0, word_vld}, {31'd0, v[32]});
            if (v[32]) check($sformatf("R1/R2/R3/R9 vec%0d word", i), word, v[31:0]);
        end

        // R5 and R6: rejected write sets error, is dropped, offset held
        rdy = 1'b0;
        do_wr(2'd0, 32'hAA);
        check("R5 err set", {31'd0, err}, 32'd1);
        check("R6 no pulse", {31'd0, word_vld}, 32'd0);
        rdy = 1'b1;
        do_wr(2'd0, 32'h01); do_wr(2'd0, 32'h02); do_wr(2'd0, 32'h03);
        rdy = 1'b0;
        do_wr(2'd0, 32'hFF);
        check("R6 dropped no pulse", {31'd0, word_vld}, 32'd0);
        rdy = 1'b1;
        do_wr(2'd0, 32'h04);
        check("R6 offset held vld", {31'd0, word_vld}, 32'd1);
        check("R6 offset held word", word, 32'h0403_0201);
        check("R5 err sticky", {31'd0, err}, 32'd1);

        // R7 clear, then set wins over clear
        pulse_err_clr();
        check("R7 err cleared", {31'd0, err}, 32'd0);
        @(negedge clk);
        rdy = 1'b0; wr_en = 1'b1; wr_size = 2'd0; err_clr = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; err_clr = 1'b0; rdy = 1'b1;
        check("R7 set wins", {31'd0, err}, 32'd1);
        pulse_err_clr();

        // R8 clear empties partial word
        do_wr(2'd0, 32'h10); do_wr(2'd0, 32'h20);
        pulse_clear();
        do_wr(2'd2, 32'hCAFE_F00D);
        check("R8 vld after clear", {31'd0, word_vld}, 32'd1);
        check("R8 word after clear", word, 32'hCAFE_F00D);
        @(negedge clk);
        clear = 1'b1; wr_en = 1'b1; wr_size = 2'd2; wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        clear = 1'b0; wr_en = 1'b0;
        check("R8 write with clear dropped", {31'd0, word_vld}, 32'd0);
        check("R8 word held", word, 32'hCAFE_F00D);
        do_wr(2'd2, 32'h0102_0304);
        check("R8 next word", word, 32'h0102_0304);

        done = 1'b1;
        finish_run();
    end

endmodule